// File: doc/BRIEF.md
# Cache Error Status and Lock Register

This block keeps the error record of a cache controller. Error detectors elsewhere in the controller send one event per cycle. Each event carries a class code, an address and an info word. The block turns each event into a sticky status-valid bit for that class. It also counts single-bit data ECC errors and keeps two overflow flags, one for correctable errors and one for uncorrectable errors. It captures the address and info word of the error that matters most. An error class is locked when both its status bit and its enable bit are set, and any locked class drives a registered asynchronous report line.

Software reaches the block through a one-cycle CSR write port. Select 0 writes the control word: the per-class enables, the data ECC check enable and the clearing-mode bit. Select 1 writes the status word: the status bits, the two overflow bits and a counter-clear strobe. The clearing-mode bit picks between plain writes and write-one-to-clear. When a hardware set and a software clear hit the same bit in one cycle, the hardware set takes effect.

Top module: `cerr_status_top`

## Requirements
- R1: After reset, the status bits, enables, overflow flags, counter, captured address, captured info and report line are all 0. The ECC check enable resets to 1 and the clearing mode resets to plain writes.
- R2: An accepted event sets the status bit whose index equals its class code. The class codes are: 0 single-bit ECC, 2 double-bit ECC, 3 tag multi-hit, 4 duplicate-tag multi-hit, 5 bus error, 6 snoop miss, 7 PIO error, 8 configuration error, 9 unexpected response. Code 1 (counter overflow) and codes 10 to 15 are ignored on the event input.
- R3: A class is locked when both its status bit and its enable bit are set. The report output is 1 exactly when some class is locked, and it is updated on the same clock edge as the status and enable registers.
- R4: The address and info words are captured only when no class is locked, or when an uncorrectable event arrives while only the correctable class 0 is locked. While any uncorrectable class is locked, they hold their values.
- R5: A configuration-error event (class 8) never updates the captured address or info.
- R6: The uncorrectable overflow flag sets when an uncorrectable event arrives while any uncorrectable class is locked.
- R7: The correctable overflow flag sets in two cases: a class-0 event arrives while any class is locked, or an uncorrectable event arrives while class 0 is locked and no uncorrectable class is locked.
- R8: Each accepted class-0 event increments the 8-bit counter. A class-0 event that arrives while the counter is at 255 leaves it at 255 and sets status bit 1.
- R9: While the ECC check enable is 0, class-0 and class-2 events change neither status, overflow flags, counter nor captured words.
- R10: Control write (select 0): bits 9:0 set the enables, bit 10 sets the ECC check enable and bit 11 sets the clearing mode. Status write (select 1): bits 9:0 address the status bits, bit 10 the correctable overflow and bit 11 the uncorrectable overflow. In plain mode these bits take the written value. In write-one-to-clear mode a 1 clears the bit and a 0 leaves it unchanged. Bit 12 = 1 clears the counter in both modes.
- R11: When a hardware event sets a bit in the same cycle that a CSR write clears it, the bit ends at 1. A counter clear in the same cycle as a class-0 event leaves the counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Error event strobe |
| ev_class | input | 4 | Class code of the event |
| ev_addr | input | ADDR_W (32) | Address attached to the event |
| ev_info | input | INFO_W (16) | Info word attached to the event |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 1 | 0 = control word, 1 = status word |
| csr_wdata | input | 13 | CSR write data |
| status_o | output | 10 | Status-valid bits per class |
| enable_o | output | 10 | Enable bits per class |
| ecc_chk_o | output | 1 | Data ECC check enable |
| w1c_mode_o | output | 1 | Write-one-to-clear mode |
| ovf_cor_o | output | 1 | Correctable overflow flag |
| ovf_unc_o | output | 1 | Uncorrectable overflow flag |
| sbe_cnt_o | output | CNT_W (8) | Single-bit ECC error count |
| err_addr_o | output | ADDR_W (32) | Captured error address |
| err_info_o | output | INFO_W (16) | Captured error info |
| async_rpt_o | output | 1 | Asynchronous error report |

## Verification
The assertions assume at most one event per cycle, held for exactly one clock, with a class code on four bits. They also assume CSR writes last one cycle and that a write and an event may coincide. The hold checks on the captured words rely on the CSR port being unable to write those words. The stimulus is driven from the falling edge, one event or write per step, and the bench deliberately pairs a clearing write with an event on the same bit only in the collision case. The counter saturation run masks class 0 so that locking does not mix into the count checks.

// File: rtl/cerr_pkg.sv
package cerr_pkg;
  localparam int NCLS  = 10;
  localparam int CLS_W = 4;
  localparam int CSR_W = 13;

  typedef enum logic [CLS_W-1:0] {
    CLS_SBE     = 4'd0,
    CLS_SBE_OVF = 4'd1,
    CLS_DBE     = 4'd2,
    CLS_TAGMH   = 4'd3,
    CLS_DUPMH   = 4'd4,
    CLS_BUS     = 4'd5,
    CLS_SNP     = 4'd6,
    CLS_PIO     = 4'd7,
    CLS_CFG     = 4'd8,
    CLS_UNEXP   = 4'd9
  } cls_e;

  // correctable classes: only single-bit data ECC
  localparam logic [NCLS-1:0] COR_MASK = NCLS'(1) << int'(CLS_SBE);

  // CSR field positions
  localparam int CB_CHK = NCLS;      // control: ECC check enable
  localparam int CB_W1C = NCLS + 1;  // control: clearing mode
  localparam int SB_OVC = NCLS;      // status: correctable overflow
  localparam int SB_OVU = NCLS + 1;  // status: uncorrectable overflow
  localparam int SB_CLR = NCLS + 2;  // status: counter clear strobe

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_STAT = 1'b1;

  typedef struct packed {
    logic lock_any;
    logic lock_unc;
    logic set_ovc;
    logic set_ovu;
    logic capture;
  } lock_dec_t;
endpackage

// File: rtl/cerr_event_filter.sv
module cerr_event_filter
  import cerr_pkg::*;
#(
  parameter int N = NCLS
) (
  input  logic             ev_valid,
  input  logic [CLS_W-1:0] ev_class,
  input  logic             ecc_chk,
  output logic             acc,
  output logic [N-1:0]     ev_vec,
  output logic             is_cor,
  output logic             is_cfg
);
  logic [N-1:0] raw;

  generate
    for (genvar g = 0; g < N; g++) begin : g_dec
      if (g == int'(CLS_SBE_OVF)) begin : g_internal
        assign raw[g] = 1'b0;
      end else if (g == int'(CLS_SBE) || g == int'(CLS_DBE)) begin : g_ecc
        assign raw[g] = ev_valid && ecc_chk && (ev_class == CLS_W'(g));
      end else begin : g_plain
        assign raw[g] = ev_valid && (ev_class == CLS_W'(g));
      end
    end
  endgenerate

  assign ev_vec = raw;
  assign acc    = |raw;
  assign is_cor = |(raw & COR_MASK);
  assign is_cfg = raw[int'(CLS_CFG)];
endmodule

// File: rtl/cerr_lock_eval.sv
module cerr_lock_eval
  import cerr_pkg::*;
#(
  parameter int N = NCLS
) (
  input  logic [N-1:0] status,
  input  logic [N-1:0] enable,
  input  logic         acc,
  input  logic         is_cor,
  input  logic         is_cfg,
  output lock_dec_t    dec
);
  logic [N-1:0] locked;
  logic lk_cor, lk_unc, lk_any;

  assign locked = status & enable;
  assign lk_cor = |(locked & COR_MASK);
  assign lk_unc = |(locked & ~COR_MASK);
  assign lk_any = lk_cor | lk_unc;

  always_comb begin
    dec.lock_any = lk_any;
    dec.lock_unc = lk_unc;
    dec.set_ovu  = acc && !is_cor && lk_unc;
    dec.set_ovc  = acc && ((is_cor && lk_any) || (!is_cor && lk_cor && !lk_unc));
    dec.capture  = acc && !is_cfg && (!lk_any || (!is_cor && !lk_unc));
  end
endmodule

// File: rtl/cerr_sbe_counter.sv
module cerr_sbe_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic at_max;
  assign at_max = (cnt == CMAX);
  assign wrap   = inc && at_max && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= inc ? CNT_W'(1) : '0;
    end else if (inc && !at_max) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (inc && at_max && !clr) |=> (cnt == CMAX)); // R8
  AST_CNT_CLR_HW_WINS: assert property (@(posedge clk) disable iff (rst)
    (clr && inc) |=> (cnt == CNT_W'(1))); // R11
endmodule

// File: rtl/cerr_status_top.sv
module cerr_status_top
  import cerr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INFO_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [CLS_W-1:0]  ev_class,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [INFO_W-1:0] ev_info,
  input  logic              csr_we,
  input  logic              csr_sel,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [NCLS-1:0]   status_o,
  output logic [NCLS-1:0]   enable_o,
  output logic              ecc_chk_o,
  output logic              w1c_mode_o,
  output logic              ovf_cor_o,
  output logic              ovf_unc_o,
  output logic [CNT_W-1:0]  sbe_cnt_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [INFO_W-1:0] err_info_o,
  output logic              async_rpt_o
);
  logic            acc, is_cor, is_cfg, wrap;
  logic [NCLS-1:0] ev_vec, hw_set;
  lock_dec_t       dec;

  logic wr_ctrl, wr_stat, cnt_clr;
  assign wr_ctrl = csr_we && (csr_sel == SEL_CTRL);
  assign wr_stat = csr_we && (csr_sel == SEL_STAT);
  assign cnt_clr = wr_stat && csr_wdata[SB_CLR];

  cerr_event_filter #(.N(NCLS)) u_filter (
    .ev_valid(ev_valid), .ev_class(ev_class), .ecc_chk(ecc_chk_o),
    .acc(acc), .ev_vec(ev_vec), .is_cor(is_cor), .is_cfg(is_cfg)
  );

  cerr_lock_eval #(.N(NCLS)) u_lock (
    .status(status_o), .enable(enable_o), .acc(acc),
    .is_cor(is_cor), .is_cfg(is_cfg), .dec(dec)
  );

  cerr_sbe_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(is_cor),
    .cnt(sbe_cnt_o), .wrap(wrap)
  );

  always_comb begin
    hw_set = ev_vec;
    hw_set[int'(CLS_SBE_OVF)] = wrap;
  end

  // software-written value of one bit under the current clearing mode
  function automatic logic sw_bit(input logic cur, input logic wr, input logic d,
                                  input logic w1c);
    if (!wr) return cur;
    return w1c ? (cur & ~d) : d;
  endfunction

  logic [NCLS-1:0] st_n, en_n;
  logic            ovc_n, ovu_n, chk_n, w1c_n;

  always_comb begin
    en_n  = wr_ctrl ? csr_wdata[NCLS-1:0] : enable_o;
    chk_n = wr_ctrl ? csr_wdata[CB_CHK]   : ecc_chk_o;
    w1c_n = wr_ctrl ? csr_wdata[CB_W1C]   : w1c_mode_o;
    for (int i = 0; i < NCLS; i++) begin
      st_n[i] = sw_bit(status_o[i], wr_stat, csr_wdata[i], w1c_mode_o) | hw_set[i];
    end
    ovc_n = sw_bit(ovf_cor_o, wr_stat, csr_wdata[SB_OVC], w1c_mode_o) | dec.set_ovc;
    ovu_n = sw_bit(ovf_unc_o, wr_stat, csr_wdata[SB_OVU], w1c_mode_o) | dec.set_ovu;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o    <= '0;
      enable_o    <= '0;
      ecc_chk_o   <= 1'b1;
      w1c_mode_o  <= 1'b0;
      ovf_cor_o   <= 1'b0;
      ovf_unc_o   <= 1'b0;
      async_rpt_o <= 1'b0;
    end else begin
      status_o    <= st_n;
      enable_o    <= en_n;
      ecc_chk_o   <= chk_n;
      w1c_mode_o  <= w1c_n;
      ovf_cor_o   <= ovc_n;
      ovf_unc_o   <= ovu_n;
      async_rpt_o <= |(st_n & en_n);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_addr_o <= '0;
      err_info_o <= '0;
    end else if (dec.capture) begin
      err_addr_o <= ev_addr;
      err_info_o <= ev_info;
    end
  end

  AST_RPT_TRACKS_LOCK: assert property (@(posedge clk) disable iff (rst)
    async_rpt_o == (|(status_o & enable_o))); // R3
  AST_UNC_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (acc && dec.lock_unc) |=> ($stable(err_addr_o) && $stable(err_info_o))); // R4
  AST_CFG_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (acc && is_cfg) |=> ($stable(err_addr_o) && $stable(err_info_o))); // R5
  AST_OVF_UNC_SETS: assert property (@(posedge clk) disable iff (rst)
    (acc && !is_cor && dec.lock_unc) |=> ovf_unc_o); // R6
  AST_OVF_COR_SETS: assert property (@(posedge clk) disable iff (rst)
    (acc && is_cor && dec.lock_any) |=> ovf_cor_o); // R7
  AST_ECC_OFF_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ecc_chk_o && !csr_we && (ev_class == CLS_DBE))
      |=> ($stable(status_o) && $stable(ovf_unc_o) && $stable(err_addr_o))); // R9
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    acc |=> ((status_o & $past(ev_vec)) == $past(ev_vec))); // R11
endmodule

// File: tb/cerr_status_top_tb_top.sv
module cerr_status_top_tb_top;
  localparam int N = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [3:0]  ev_class = '0;
  logic [31:0] ev_addr = '0;
  logic [15:0] ev_info = '0;
  logic        csr_we = 1'b0;
  logic        csr_sel = 1'b0;
  logic [12:0] csr_wdata = '0;
  logic [N-1:0] status_o, enable_o;
  logic        ecc_chk_o, w1c_mode_o, ovf_cor_o, ovf_unc_o, async_rpt_o;
  logic [7:0]  sbe_cnt_o;
  logic [31:0] err_addr_o;
  logic [15:0] err_info_o;

  always #10 clk = ~clk;  // 50 MHz

  cerr_status_top dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_class(ev_class),
    .ev_addr(ev_addr), .ev_info(ev_info), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .status_o(status_o), .enable_o(enable_o),
    .ecc_chk_o(ecc_chk_o), .w1c_mode_o(w1c_mode_o), .ovf_cor_o(ovf_cor_o),
    .ovf_unc_o(ovf_unc_o), .sbe_cnt_o(sbe_cnt_o), .err_addr_o(err_addr_o),
    .err_info_o(err_info_o), .async_rpt_o(async_rpt_o)
  );

  typedef struct {
    logic [N-1:0] st;
    logic         ovc, ovu, rpt;
    logic [7:0]   cnt;
    logic [31:0]  addr;
    logic [15:0]  info;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;

  // reference state built from the requirements
  logic [N-1:0] m_st = '0, m_en = '0;
  logic m_chk = 1'b1, m_w1c = 1'b0, m_ovc = 1'b0, m_ovu = 1'b0;
  logic [7:0] m_cnt = '0;
  logic [31:0] m_addr = '0;
  logic [15:0] m_info = '0;

  task automatic step(input bit ev, input logic [3:0] cls, input logic [31:0] a,
                      input logic [15:0] inf, input bit we, input bit sel,
                      input logic [12:0] wd, input string tag);
    bit ok, cor, lk_cor, lk_unc, lk_any;
    logic [N-1:0] lk, nst, nen;
    exp_t e;
    @(negedge clk);
    ev_valid = ev; ev_class = cls; ev_addr = a; ev_info = inf;
    csr_we = we; csr_sel = sel; csr_wdata = wd;
    // R2 / R9 acceptance
    ok = ev && cls != 4'd1 && cls < 4'd10 && !((cls == 4'd0 || cls == 4'd2) && !m_chk);
    cor = ok && cls == 4'd0;
    lk = m_st & m_en;
    lk_cor = lk[0]; lk_unc = |lk[N-1:1]; lk_any = |lk;
    nst = m_st; nen = m_en;
    if (we && sel) begin
      nst = m_w1c ? (m_st & ~wd[N-1:0]) : wd[N-1:0];
      m_ovc = m_w1c ? (m_ovc & ~wd[10]) : wd[10];
      m_ovu = m_w1c ? (m_ovu & ~wd[11]) : wd[11];
    end
    if (ok && !cor && lk_unc) m_ovu = 1'b1;                       // R6
    if (ok && ((cor && lk_any) || (!cor && lk_cor && !lk_unc))) m_ovc = 1'b1; // R7
    if (ok && cls != 4'd8 && (!lk_any || (!cor && !lk_unc))) begin // R4 R5
      m_addr = a; m_info = inf;
    end
    if (ok) nst[cls] = 1'b1;
    if (we && sel && wd[12]) m_cnt = cor ? 8'd1 : 8'd0;           // R11
    else if (cor) begin
      if (m_cnt == 8'hFF) nst[1] = 1'b1;                          // R8
      else m_cnt = m_cnt + 8'd1;
    end
    if (we && !sel) begin
      nen = wd[N-1:0]; m_chk = wd[10]; m_w1c = wd[11];
    end
    m_st = nst; m_en = nen;
    @(posedge clk);
    #1;
    ev_valid = 1'b0; csr_we = 1'b0;
    e.st = m_st; e.ovc = m_ovc; e.ovu = m_ovu; e.rpt = |(m_st & m_en);
    e.cnt = m_cnt; e.addr = m_addr; e.info = m_info; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string fld, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
    end
  endtask

  // monitor: compare design outputs against the scoreboard away from the edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "status", 32'(status_o), 32'(e.st));
      cmp(e.tag, "ovf_cor", 32'(ovf_cor_o), 32'(e.ovc));
      cmp(e.tag, "ovf_unc", 32'(ovf_unc_o), 32'(e.ovu));
      cmp(e.tag, "count", 32'(sbe_cnt_o), 32'(e.cnt));
      cmp(e.tag, "addr", err_addr_o, e.addr);
      cmp(e.tag, "info", 32'(err_info_o), 32'(e.info));
      cmp(e.tag, "report", 32'(async_rpt_o), 32'(e.rpt));
    end
  end

  task automatic idle(input string tag);
    step(1'b0, 4'd0, '0, '0, 1'b0, 1'b0, '0, tag);
  endtask
  task automatic evt(input logic [3:0] c, input logic [31:0] a, input logic [15:0] i,
                     input string tag);
    step(1'b1, c, a, i, 1'b0, 1'b0, '0, tag);
  endtask
  task automatic wr(input bit sel, input logic [12:0] d, input string tag);
    step(1'b0, 4'd0, '0, '0, 1'b1, sel, d, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle("R1_reset");
    @(negedge clk);
    checks++;
    if (enable_o !== '0 || ecc_chk_o !== 1'b1 || w1c_mode_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 ctrl actual=%0h/%0b/%0b expected=0/1/0", enable_o, ecc_chk_o, w1c_mode_o);
    end

    wr(1'b0, 13'h07FF, "R10_ctrl_enable_all");
    checks++;
    @(negedge clk);
    if (enable_o !== 10'h3FF) begin
      failures++;
      $display("FAIL R10 enables actual=%0h expected=3ff", enable_o);
    end
    evt(4'd0, 32'hA000_0001, 16'h0011, "R2_R3_R8_first_sbe");
    evt(4'd0, 32'hA000_0002, 16'h0022, "R7_sbe_while_locked");
    evt(4'd2, 32'hA000_0003, 16'h0033, "R4_R7_unc_replaces_cor");
    evt(4'd3, 32'hA000_0004, 16'h0044, "R4_R6_unc_while_unc");
    evt(4'd1, 32'hA000_0005, 16'h0055, "R2_code1_ignored");
    evt(4'd12, 32'hA000_0006, 16'h0066, "R2_code12_ignored");
    wr(1'b1, 13'h0000, "R10_plain_clear_all");
    evt(4'd8, 32'hB000_0001, 16'h0101, "R5_cfg_no_capture");
    wr(1'b1, 13'h0000, "R10_plain_clear_cfg");
    wr(1'b1, 13'h0C20, "R10_plain_set_bits");
    wr(1'b0, 13'h0FFF, "R10_select_w1c");
    wr(1'b1, 13'h0020, "R10_w1c_clear_bit5");
    wr(1'b1, 13'h0000, "R10_w1c_zero_no_effect");
    wr(1'b1, 13'h0C00, "R10_w1c_clear_ovf");
    step(1'b1, 4'd3, 32'hC000_0001, 16'h0202, 1'b1, 1'b1, 13'h0008, "R11_hw_set_wins");
    wr(1'b1, 13'h1FFF, "R10_w1c_clear_all");
    wr(1'b0, 13'h03FF, "R9_ecc_off");
    evt(4'd0, 32'hD000_0001, 16'h0303, "R9_sbe_ignored");
    evt(4'd2, 32'hD000_0002, 16'h0304, "R9_dbe_ignored");
    evt(4'd9, 32'hD000_0003, 16'h0305, "R2_R3_unexp");
    wr(1'b0, 13'h0400, "R3_disable_all");
    evt(4'd5, 32'hE000_0001, 16'h0401, "R4_unlocked_capture");
    evt(4'd6, 32'hE000_0002, 16'h0402, "R4_unlocked_capture2");
    wr(1'b1, 13'h1000, "R10_counter_clear");
    for (int k = 0; k < 256; k++) evt(4'd0, 32'hF000_0000 + k, 16'h0500, "R8_count");
    evt(4'd0, 32'hF000_1000, 16'h0501, "R8_saturate");
    step(1'b1, 4'd0, 32'hF000_2000, 16'h0502, 1'b1, 1'b1, 13'h1002, "R11_clear_and_sbe");
    idle("R1_idle_final");
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R0 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule